// File: doc/BRIEF.md
# Shared Buffer DMA Offset and Sector Counter

This block sits between two peripheral controllers and one small shared buffer memory. It turns a wide DMA start address into an offset inside a fixed 16 KiB window and steps that offset once for every byte moved. It also counts the transfer length, given in sectors, down to a one-cycle terminal-count pulse. Software sets it up with byte-wide register writes: three address bytes, a control byte that picks the sector size and the length encoding, and a length byte. The length write starts the transfer.

Only one requester may use the buffer and the counter at a time. Each requester raises a lock request and waits for its grant. The owner keeps the grant until it drops its request or its transfer reaches terminal count. Register writes and transfer strobes that do not come from the owner are dropped. So are register writes made while a transfer is running. Each dropped access sets a sticky violation flag. This way a transfer in flight cannot be disturbed by the other side.

Top module: `shared_buf_dma`

## Requirements
- R1: When no requester owns the lock, a request is granted on the next clock edge. If both request in the same cycle, requester 0 wins. At most one grant bit is ever high.
- R2: The owner keeps its grant for as long as it holds its request. When it drops the request, the grant clears on the next edge, and any running transfer stops without a terminal-count pulse.
- R3: An owner write to index 0 loads offset bits 7:0 from data bits 7:0. A write to index 1 loads offset bits 13:8 from data bits 5:0; data bits 7:6 are ignored. A write to index 2 (address bits 23:16) is accepted but leaves the offset unchanged.
- R4: A write to index 7 sets the control byte. Bit 0 = 1 selects twos-complement length and bit 0 = 0 selects ones-complement length. Bits 2:1 = 0, 1, 2, 3 select a sector size of 128, 256, 512 or 1024 bytes.
- R5: A write to index 6 loads the length and starts a transfer (xfer_active = 1). For N sectors, the ones-complement value is 8'hFF - N and the twos-complement value is 8'h100 - N. A value meaning zero sectors (8'hFF in ones mode, 8'h00 in twos mode) starts no transfer.
- R6: Each accepted strobe advances buf_addr by one, and the address wraps from 14'h3FFF to 14'h0000.
- R7: The byte count restarts at each sector boundary. Terminal count is reached after exactly N × sector-size accepted strobes. On that edge, tc rises for exactly one cycle, xfer_active falls and the grant is released.
- R8: These accesses are ignored and leave buf_addr and the transfer state unchanged: a register write from a non-owner, a register write with no owner, a register write during a transfer, a strobe from a non-owner, and a strobe with no transfer running. Each one sets `violation`, which stays high until reset.
- R9: After a terminal-count release, no grant is given for one cycle. Arbitration then starts afresh, so requester 0 wins even if requester 1 just finished and still requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_req | input | 2 | Lock request, one bit per requester |
| lock_gnt | output | 2 | Lock grant, one bit per requester |
| reg_wr | input | 1 | Register write strobe |
| reg_src | input | 1 | Requester issuing the register write |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 8 | Register write data |
| xfer_stb | input | 1 | One byte transferred |
| xfer_src | input | 1 | Requester issuing the strobe |
| buf_addr | output | 14 | Buffer offset of the current byte |
| xfer_active | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal-count pulse |
| violation | output | 1 | Sticky rejected-access flag |

## Verification
The bench builds the block with its default parameters: a 14-bit offset, a 24-bit address, an 8-bit sector count and a 128-byte base sector. With these values, every sector size runs to completion in at most 1024 strobes. Both length encodings, the offset wrap at 14'h3FFF and the dropped upper address byte can all be reached with directed sequences. A two-sector transfer started near the top of the window covers the wrap and the sector rollover in one pass.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   typedef enum logic [2:0] {
      IDX_ADR_LO  = 3'd0,
      IDX_ADR_MID = 3'd1,
      IDX_ADR_HI  = 3'd2,
      IDX_LENGTH  = 3'd6,
      IDX_CONTROL = 3'd7
   } sbd_idx_e;

   localparam int CTL_TWOS_BIT = 0;
   localparam int CTL_SIZE_LSB = 1;
endpackage

// File: rtl/sbd_lock_arb.sv
module sbd_lock_arb #(
   parameter int NREQ = 2,
   localparam int IDW = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   input  logic            done,
   output logic            owner_vld,
   output logic [IDW-1:0]  owner_id,
   output logic [NREQ-1:0] gnt
);
   logic [IDW-1:0] pick;
   logic           drop;

   always_comb begin
      pick = '0;
      for (int i = NREQ - 1; i >= 0; i--)
         if (req[i]) pick = IDW'(i);
   end

   assign drop = owner_vld && (done || !req[owner_id]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_vld <= 1'b0;
         owner_id  <= '0;
      end else if (drop) begin
         owner_vld <= 1'b0;
      end else if (!owner_vld && (|req)) begin
         owner_vld <= 1'b1;
         owner_id  <= pick;
      end
   end

   always_comb begin
      gnt = '0;
      if (owner_vld) gnt[owner_id] = 1'b1;
   end

   // R1: idle lock with requester 0 asking goes to requester 0
   p_tie_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_vld && req[0]) |=> gnt[0]);
   // R2: grant held while the owner keeps requesting
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_vld && req[owner_id] && !done) |=> (owner_vld && $stable(owner_id)));
   // R9: terminal count forces one ungranted cycle
   p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_vld && done) |=> (gnt == '0));
endmodule

// File: rtl/sbd_addr.sv
module sbd_addr #(
   parameter int OFS_W  = 14,
   parameter int ADDR_W = 24,
   localparam int LANES = ADDR_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_lane,
   input  logic [7:0]       wdata,
   input  logic             inc,
   output logic [OFS_W-1:0] ofs
);
   logic [OFS_W-1:0] wr_mask, wr_val, ofs_nxt;
   logic             lint_unused_data;

   assign lint_unused_data = ^wdata;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k * 8 < OFS_W) begin : g_used
         localparam int LW = (OFS_W - k * 8 > 8) ? 8 : OFS_W - k * 8;
         assign wr_mask[k*8 +: LW] = {LW{wr_en && (wr_lane == 3'(k))}};
         assign wr_val[k*8 +: LW]  = wdata[LW-1:0];
      end else begin : g_dropped
         // address bits above the buffer window have no storage
      end
   end

   always_comb begin
      ofs_nxt = (ofs & ~wr_mask) | (wr_val & wr_mask);
      if (inc) ofs_nxt = ofs + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs <= '0;
      else        ofs <= ofs_nxt;
   end

   // R6: offset steps by one per accepted byte, wrapping at the window top
   p_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_en) |=> (ofs == OFS_W'($past(ofs) + 1'b1)));
   // R3: writes to lanes beyond the window leave the offset alone
   p_hilane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !inc && (wr_lane >= 3'((OFS_W + 7) / 8))) |=> $stable(ofs));
endmodule

// File: rtl/sbd_xfer_cnt.sv
module sbd_xfer_cnt #(
   parameter int SEC_W     = 8,
   parameter int BASE_LOG2 = 7,
   parameter int SEL_W     = 2,
   localparam int BCNT_W   = BASE_LOG2 + (1 << SEL_W) - 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic       len_we,
   input  logic [7:0] wdata,
   input  logic       stb,
   input  logic       abort,
   output logic       active,
   output logic       tc_fire,
   output logic       tc
);
   import sbd_pkg::*;

   localparam logic [SEC_W-1:0] SEC_END = {{(SEC_W-1){1'b1}}, 1'b0};
   localparam logic [BCNT_W-1:0] ONES   = '1;

   logic              twos;
   logic [SEL_W-1:0]  sel;
   logic [SEC_W-1:0]  sec, len_ld;
   logic [BCNT_W-1:0] bcnt, last_val;
   logic              last_byte;

   assign len_ld    = twos ? (wdata[SEC_W-1:0] - 1'b1) : wdata[SEC_W-1:0];
   assign last_val  = ~(ONES << (BASE_LOG2 + 32'(sel)));
   assign last_byte = (bcnt == last_val);
   assign tc_fire   = stb && active && last_byte && (sec == SEC_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         twos <= 1'b0; sel <= '0; sec <= '1; bcnt <= '0;
         active <= 1'b0; tc <= 1'b0;
      end else begin
         tc <= tc_fire;
         if (ctl_we) begin
            twos <= wdata[CTL_TWOS_BIT];
            sel  <= wdata[CTL_SIZE_LSB +: SEL_W];
         end
         if (len_we) begin
            sec    <= len_ld;
            bcnt   <= '0;
            active <= (len_ld != '1);
         end else if (abort) begin
            active <= 1'b0;
         end else if (stb && active) begin
            if (last_byte) begin
               bcnt <= '0;
               if (sec == SEC_END) active <= 1'b0;
               else                sec    <= sec + 1'b1;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end
      end
   end

   // R7: terminal count is a single-cycle pulse and ends the transfer
   p_tc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc);
   p_tc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> !active);
   // R8: without an accepted byte or load the counts stand still
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb && !len_we) |=> ($stable(sec) && $stable(bcnt)));
endmodule

// File: rtl/shared_buf_dma.sv
module shared_buf_dma #(
   parameter int OFS_W     = 14,
   parameter int ADDR_W    = 24,
   parameter int SEC_W     = 8,
   parameter int BASE_LOG2 = 7,
   parameter int NREQ      = 2,
   localparam int IDW      = (NREQ > 1) ? $clog2(NREQ) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NREQ-1:0]  lock_req,
   output logic [NREQ-1:0]  lock_gnt,
   input  logic             reg_wr,
   input  logic [IDW-1:0]   reg_src,
   input  logic [2:0]       reg_idx,
   input  logic [7:0]       reg_wdata,
   input  logic             xfer_stb,
   input  logic [IDW-1:0]   xfer_src,
   output logic [OFS_W-1:0] buf_addr,
   output logic             xfer_active,
   output logic             tc,
   output logic             violation
);
   import sbd_pkg::*;

   if (OFS_W > ADDR_W || ADDR_W % 8 != 0 || ADDR_W > 64) begin : g_bad_addr
      $error("address widths out of range");
   end
   if (SEC_W < 2 || SEC_W > 8) begin : g_bad_sec
      $error("sector count must fit the length byte");
   end

   logic           owner_vld, tc_fire, abort;
   logic [IDW-1:0] owner_id;
   logic           own_wr, bad_wr, own_stb, bad_stb;

   assign abort   = owner_vld && !lock_req[owner_id];
   assign own_wr  = reg_wr && owner_vld && (reg_src == owner_id) && !xfer_active;
   assign bad_wr  = reg_wr && !own_wr;
   assign own_stb = xfer_stb && xfer_active && owner_vld && (xfer_src == owner_id);
   assign bad_stb = xfer_stb && !own_stb;

   sbd_lock_arb #(.NREQ(NREQ)) u_arb (
      .clk, .rst_n, .req(lock_req), .done(tc_fire),
      .owner_vld, .owner_id, .gnt(lock_gnt)
   );

   sbd_addr #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_addr (
      .clk, .rst_n, .wr_en(own_wr), .wr_lane(reg_idx), .wdata(reg_wdata),
      .inc(own_stb), .ofs(buf_addr)
   );

   sbd_xfer_cnt #(.SEC_W(SEC_W), .BASE_LOG2(BASE_LOG2)) u_cnt (
      .clk, .rst_n,
      .ctl_we(own_wr && (reg_idx == IDX_CONTROL)),
      .len_we(own_wr && (reg_idx == IDX_LENGTH)),
      .wdata(reg_wdata), .stb(own_stb), .abort(abort),
      .active(xfer_active), .tc_fire, .tc
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  violation <= 1'b0;
      else if (bad_wr || bad_stb)  violation <= 1'b1;
   end

   // R8: the violation flag never clears outside reset
   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);
   // R8: a rejected write does not move the offset
   p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_wr && !own_stb) |=> $stable(buf_addr));
   // R2: dropping the request ends any running transfer
   p_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !xfer_active);
endmodule

// File: tb/shared_buf_dma_test.sv
module shared_buf_dma_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [1:0]  lock_req = '0;
   logic [1:0]  lock_gnt;
   logic        reg_wr = 1'b0, reg_src = 1'b0, xfer_stb = 1'b0, xfer_src = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic [13:0] buf_addr;
   logic        xfer_active, tc, violation;
   int          checks = 0, failures = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shared_buf_dma uut (
      .clk, .rst_n, .lock_req, .lock_gnt, .reg_wr, .reg_src, .reg_idx, .reg_wdata,
      .xfer_stb, .xfer_src, .buf_addr, .xfer_active, .tc, .violation
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic src, logic [2:0] idx, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_src = src; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic strobe(logic src, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         xfer_stb = 1'b1; xfer_src = src;
      end
      @(negedge clk);
      xfer_stb = 1'b0;
   endtask

   task automatic acquire(int who);
      lock_req[who] = 1'b1;
      for (int i = 0; i < 4 && !lock_gnt[who]; i++) @(negedge clk);
      chk("R1 acquire", 32'(lock_gnt), 32'(1 << who));
   endtask

   task automatic t_reset;
      chk("R1 reset grant", 32'(lock_gnt), 0);
      chk("R6 reset addr", 32'(buf_addr), 0);
      chk("R7 reset tc", 32'(tc), 0);
      chk("R5 reset active", 32'(xfer_active), 0);
      chk("R8 reset violation", 32'(violation), 0);
   endtask

   task automatic t_arb;
      @(negedge clk); lock_req = 2'b01;
      @(negedge clk); chk("R1 single grant", 32'(lock_gnt), 32'h1);
      lock_req = 2'b11;
      @(negedge clk); chk("R2 grant held", 32'(lock_gnt), 32'h1);
      lock_req = 2'b10;
      @(negedge clk); chk("R2 release", 32'(lock_gnt), 32'h0);
      @(negedge clk); chk("R1 other side", 32'(lock_gnt), 32'h2);
      lock_req = 2'b00;
      @(negedge clk); chk("R2 release 1", 32'(lock_gnt), 32'h0);
      lock_req = 2'b11;
      @(negedge clk); chk("R1 tie to 0", 32'(lock_gnt), 32'h1);
      lock_req = 2'b01;
   endtask

   task automatic t_regmap;
      wr(0, 3'd0, 8'h34);
      wr(0, 3'd1, 8'hFF);
      chk("R3 low and mid lanes", 32'(buf_addr), 32'h3F34);
      wr(0, 3'd2, 8'hAB);
      chk("R3 upper byte dropped", 32'(buf_addr), 32'h3F34);
      chk("R8 owner writes clean", 32'(violation), 0);
   endtask

   task automatic t_ones_wrap;
      wr(0, 3'd0, 8'hC0);
      wr(0, 3'd1, 8'h3F);
      wr(0, 3'd7, 8'h00);
      wr(0, 3'd6, 8'hFD);
      chk("R5 ones start", 32'(xfer_active), 1);
      strobe(0, 64);
      chk("R6 wrap to zero", 32'(buf_addr), 0);
      strobe(0, 191);
      chk("R7 no early tc", 32'(tc), 0);
      chk("R7 still active", 32'(xfer_active), 1);
      chk("R6 address mid", 32'(buf_addr), 32'hBF);
      strobe(0, 1);
      chk("R7 tc after 2x128", 32'(tc), 1);
      chk("R7 active drops", 32'(xfer_active), 0);
      chk("R7 grant released", 32'(lock_gnt), 0);
      chk("R6 final addr", 32'(buf_addr), 32'hC0);
      @(negedge clk);
      chk("R7 tc one cycle", 32'(tc), 0);
      chk("R9 regrant", 32'(lock_gnt), 32'h1);
   endtask

   task automatic t_sizes;
      for (int s = 1; s <= 2; s++) begin
         acquire(0);
         wr(0, 3'd0, 8'h00);
         wr(0, 3'd1, 8'h00);
         wr(0, 3'd7, 8'(s << 1));
         wr(0, 3'd6, 8'hFE);
         strobe(0, (128 << s) - 1);
         chk("R4 size no tc yet", 32'(tc), 0);
         strobe(0, 1);
         chk("R4 size tc", 32'(tc), 1);
         chk("R4 size addr", 32'(buf_addr), 32'(128 << s));
         @(negedge clk);
      end
   endtask

   task automatic t_zero;
      acquire(0);
      wr(0, 3'd7, 8'h00);
      wr(0, 3'd6, 8'hFF);
      chk("R5 ones zero length", 32'(xfer_active), 0);
      wr(0, 3'd7, 8'h01);
      wr(0, 3'd6, 8'h00);
      chk("R5 twos zero length", 32'(xfer_active), 0);
   endtask

   task automatic t_twos_tie;
      lock_req = 2'b00;
      @(negedge clk); @(negedge clk);
      acquire(1);
      wr(1, 3'd0, 8'h00);
      wr(1, 3'd1, 8'h10);
      wr(1, 3'd7, 8'h07);
      wr(1, 3'd6, 8'hFF);
      chk("R5 twos one sector", 32'(xfer_active), 1);
      strobe(1, 1023);
      chk("R4 1024 no tc yet", 32'(tc), 0);
      lock_req = 2'b11;
      strobe(1, 1);
      chk("R7 twos tc", 32'(tc), 1);
      chk("R7 twos grant off", 32'(lock_gnt), 0);
      chk("R6 twos addr", 32'(buf_addr), 32'h1400);
      @(negedge clk);
      chk("R9 fresh tie to 0", 32'(lock_gnt), 32'h1);
      chk("R7 twos tc low", 32'(tc), 0);
      lock_req = 2'b01;
   endtask

   task automatic t_abort;
      wr(0, 3'd7, 8'h00);
      wr(0, 3'd6, 8'hFE);
      strobe(0, 10);
      lock_req = 2'b00;
      @(negedge clk);
      chk("R2 abort grant", 32'(lock_gnt), 0);
      chk("R2 abort active", 32'(xfer_active), 0);
      chk("R2 abort no tc", 32'(tc), 0);
      chk("R8 still clean", 32'(violation), 0);
   endtask

   task automatic t_violation;
      logic [13:0] a;
      acquire(0);
      a = buf_addr;
      wr(1, 3'd0, 8'h55);
      chk("R8 foreign write ignored", 32'(buf_addr), 32'(a));
      chk("R8 violation set", 32'(violation), 1);
      wr(0, 3'd6, 8'hFE);
      wr(0, 3'd0, 8'h77);
      chk("R8 write during transfer", 32'(buf_addr), 32'(a));
      strobe(1, 3);
      chk("R8 foreign strobe", 32'(buf_addr), 32'(a));
      strobe(0, 2);
      chk("R6 owner strobe", 32'(buf_addr), 32'(14'(a + 2)));
      lock_req = 2'b00;
      repeat (3) @(negedge clk);
      chk("R8 violation sticky", 32'(violation), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arb();
      t_regmap();
      t_ones_wrap();
      t_sizes();
      t_zero();
      t_twos_tie();
      acquire(0);
      t_abort();
      t_violation();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule